// File: doc/BRIEF.md
# Slave Serial Configuration Sequencer

This block loads a configuration bit stream into a programmable logic device through its slave-serial port. It drives the device's program-request pin, its configuration clock and its serial data pin, and it watches the device's init and done status lines.

A pulse on `start` begins the sequence. The block first asserts program and waits for init to fall. It then releases program and waits for init to rise again. After that it can shift out a fixed 16-bit header, and then the stream bits it receives on a valid/ready interface. When the bit marked last has gone out, it waits for done. Each of the three waits has its own timeout, counted in system clock cycles, and its own error code.

Every bit takes four system clock cycles. New stream data is accepted only while the configuration clock is low. The block then holds `finished` and the result code until the next `start`. Init and done pass through two-flop synchronisers before the block uses them.

Top module: `cfg_serial_loader`

## Requirements
- R1: In reset, `prog_pin` is at its inactive level, `cclk` and `din` are high, `bit_ready` is low and `finished` is low.
- R2: One cycle after `start` is sampled, `prog_pin` is at its active level. The active level is high when `PROG_ACTIVE_HIGH` is 1 and low otherwise (the default).
- R3: If the synchronised init stays high for `TIMEOUT_TICKS` cycles while program is asserted, the block finishes with `result` = 1. `finished` rises exactly `TIMEOUT_TICKS` clock edges after the edge that sampled `start`.
- R4: After init falls, program is released. If init then stays low for `TIMEOUT_TICKS` cycles, the block finishes with `result` = 2.
- R5: Each bit is sent in four steps, one cycle each: `cclk` low with `din` high; `din` set to the bit with `cclk` low; `cclk` raised; `din` returned high with `cclk` still high. So `din` is high whenever `cclk` falls, and `din` does not change when `cclk` rises.
- R6: With `PREAMBLE_EN` = 1 (the default), the 16 bits of 0xFF20, most significant bit first, are shifted out before any stream bit.
- R7: `bit_ready` is high only in the clock-low step and only after the header. Stream bits appear on `din` in the order they were accepted.
- R8: After the bit accepted with `bit_last` = 1, the block waits for done. If done goes high it finishes with `result` = 0. If done stays low for `TIMEOUT_TICKS` cycles, it finishes with `result` = 3.
- R9: Once finished, `finished` and `result` hold their values, and `prog_pin`, `cclk` and `din` are idle, until a new `start` begins another sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a configuration sequence (accepted when idle or finished) |
| bit_valid | input | 1 | Stream bit available |
| bit_data | input | 1 | Stream bit value |
| bit_last | input | 1 | Marks the final stream bit |
| bit_ready | output | 1 | Stream bit accepted this cycle when valid |
| prog_pin | output | 1 | Program request to the device |
| cclk | output | 1 | Configuration clock to the device |
| din | output | 1 | Serial configuration data |
| init_pin | input | 1 | Device init status, asynchronous |
| done_pin | input | 1 | Device done status, asynchronous |
| busy | output | 1 | A sequence is in progress |
| finished | output | 1 | Sequence over; result valid |
| result | output | 2 | 0 success, 1 init never fell, 2 init never rose, 3 done never rose |

## Verification
A small device model in the bench answers the program pin and captures `din` on each rising `cclk`. It is run through a table of cases. In the normal cases, stream words such as 0xA53C, 0x0000 and 0x8001 expose bit-order and header errors, because the header bits and the stream bits differ in position and polarity. Three fault modes each stall the device in a different phase: init held high, init held low after release, and done never rising. Each fault must yield its own code, so a swapped phase or a shared timeout shows up directly. Directed checks then cover the reset levels, the exact timeout edge, and the holding of the result.

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader #(
  parameter bit PROG_ACTIVE_HIGH = 1'b0,
  parameter bit PREAMBLE_EN      = 1'b1,
  parameter int TIMEOUT_TICKS    = 300000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       bit_valid,
  input  logic       bit_data,
  input  logic       bit_last,
  output logic       bit_ready,
  output logic       prog_pin,
  output logic       cclk,
  output logic       din,
  input  logic       init_pin,
  input  logic       done_pin,
  output logic       busy,
  output logic       finished,
  output logic [1:0] result
);
  localparam int CW = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [15:0] HEADER = 16'hFF20;
  localparam logic [4:0] HDR_LEN = 5'd16;

  typedef enum logic [3:0] {
    S_IDLE, S_PROG, S_REL, S_LO, S_DAT, S_HI, S_RET, S_WDONE, S_END
  } state_t;

  state_t      st;
  logic [CW-1:0] cnt;
  logic [4:0]  hdr_idx;
  logic        cur_bit, cur_last;
  logic [1:0]  init_q, done_q;
  logic        init_s, done_s, hdr_done, tmo;

  assign init_s   = init_q[1];
  assign done_s   = done_q[1];
  assign hdr_done = (hdr_idx == HDR_LEN);
  assign tmo      = (cnt == CW'(TIMEOUT_TICKS - 1));

  assign bit_ready = (st == S_LO) && hdr_done;
  assign prog_pin  = PROG_ACTIVE_HIGH ? (st == S_PROG) : (st != S_PROG);
  assign cclk      = !(st == S_LO || st == S_DAT);
  assign din       = (st == S_DAT || st == S_HI) ? cur_bit : 1'b1;
  assign busy      = !(st == S_IDLE || st == S_END);
  assign finished  = (st == S_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= 2'b11;
      done_q <= 2'b00;
    end else begin
      init_q <= {init_q[0], init_pin};
      done_q <= {done_q[0], done_pin};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      hdr_idx  <= '0;
      cur_bit  <= 1'b1;
      cur_last <= 1'b0;
      result   <= 2'd0;
    end else begin
      case (st)
        S_IDLE, S_END: if (start) begin
          st      <= S_PROG;
          cnt     <= '0;
          result  <= 2'd0;
          hdr_idx <= PREAMBLE_EN ? 5'd0 : HDR_LEN;
        end
        S_PROG: begin
          if (!init_s) begin
            st  <= S_REL;
            cnt <= '0;
          end else if (tmo) begin
            st     <= S_END;
            result <= 2'd1;
          end else cnt <= cnt + 1'b1;
        end
        S_REL: begin
          if (init_s) st <= S_LO;
          else if (tmo) begin
            st     <= S_END;
            result <= 2'd2;
          end else cnt <= cnt + 1'b1;
        end
        S_LO: begin
          if (!hdr_done) begin
            cur_bit  <= HEADER[4'd15 - hdr_idx[3:0]];
            cur_last <= 1'b0;
            hdr_idx  <= hdr_idx + 1'b1;
            st       <= S_DAT;
          end else if (bit_valid) begin
            cur_bit  <= bit_data;
            cur_last <= bit_last;
            st       <= S_DAT;
          end
        end
        S_DAT: st <= S_HI;
        S_HI:  st <= S_RET;
        S_RET: begin
          st  <= cur_last ? S_WDONE : S_LO;
          cnt <= '0;
        end
        S_WDONE: begin
          if (done_s) begin
            st     <= S_END;
            result <= 2'd0;
          end else if (tmo) begin
            st     <= S_END;
            result <= 2'd3;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module cfg_serial_loader_chk #(
  parameter bit PROG_ACTIVE_HIGH = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       bit_ready,
  input logic       prog_pin,
  input logic       cclk,
  input logic       din,
  input logic       busy,
  input logic       finished,
  input logic [1:0] result
);
  AST_READY_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    bit_ready |-> !cclk); // R7
  AST_DIN_HIGH_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cclk) |-> (din && $past(din))); // R5
  AST_DIN_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cclk) |-> $stable(din)); // R5
  AST_PROG_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_pin == PROG_ACTIVE_HIGH) |-> busy); // R2
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (finished && !start) |=> (finished && $stable(result))); // R9
  AST_IDLE_PINS_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    finished |-> (cclk && din && prog_pin != PROG_ACTIVE_HIGH)); // R9
endmodule

bind cfg_serial_loader cfg_serial_loader_chk #(.PROG_ACTIVE_HIGH(PROG_ACTIVE_HIGH)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .bit_ready(bit_ready),
  .prog_pin(prog_pin), .cclk(cclk), .din(din), .busy(busy),
  .finished(finished), .result(result)
);

// File: tb/test_cfg_serial_loader.sv
module test_cfg_serial_loader;
  localparam int TMO = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, bit_valid = 1'b0, bit_data = 1'b0, bit_last = 1'b0;
  logic bit_ready, prog_pin, cclk, din, busy, finished;
  logic [1:0] result;
  logic init_pin = 1'b1, done_pin = 1'b0;

  int checks = 0, errors = 0;
  logic [1:0] mode = 2'd0;
  logic [31:0] cap = '0;
  int capcnt = 0;
  logic prev_cclk = 1'b1;

  always #5 clk = ~clk;

  cfg_serial_loader #(.TIMEOUT_TICKS(TMO)) i_cfg_serial_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .bit_valid(bit_valid),
    .bit_data(bit_data), .bit_last(bit_last), .bit_ready(bit_ready),
    .prog_pin(prog_pin), .cclk(cclk), .din(din), .init_pin(init_pin),
    .done_pin(done_pin), .busy(busy), .finished(finished), .result(result)
  );

  // device model: mode 0 normal, 1 init stuck high, 2 init stuck low, 3 no done
  always @(posedge clk) begin
    prev_cclk <= cclk;
    if (prog_pin == 1'b0) begin
      if (mode != 2'd1) init_pin <= 1'b0;
      done_pin <= 1'b0;
      capcnt   <= 0;
    end else begin
      if (mode != 2'd2) init_pin <= 1'b1;
      if (!prev_cclk && cclk) begin
        cap    <= {cap[30:0], din};
        capcnt <= capcnt + 1;
      end
      done_pin <= (mode != 2'd3) && (capcnt == 32);
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(posedge clk);
    @(negedge clk) start = 1'b0;
  endtask

  task automatic send_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk);
      bit_valid = 1'b1; bit_data = w[i]; bit_last = (i == 0);
      while (!bit_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk) bit_valid = 1'b0; bit_last = 1'b0;
  endtask

  task automatic wait_finish();
    while (!finished) @(negedge clk);
  endtask

  // {mode, expected result, stream word}
  localparam logic [19:0] VEC [6] = '{
    {2'd0, 2'd0, 16'hA53C}, {2'd1, 2'd1, 16'h0000}, {2'd0, 2'd0, 16'h0000},
    {2'd2, 2'd2, 16'h1111}, {2'd3, 2'd3, 16'h1234}, {2'd0, 2'd0, 16'h8001}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 prog", prog_pin, 1);
    check("R1 cclk", cclk, 1);
    check("R1 din", din, 1);
    check("R1 ready", bit_ready, 0);
    check("R1 finished", finished, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      mode = VEC[v][19:18];
      pulse_start();
      check("R2 prog active", prog_pin, 0);
      if (mode == 2'd0 || mode == 2'd3) send_word(VEC[v][15:0]);
      wait_finish();
      check("R3 R4 R8 result", result, VEC[v][17:16]);
      if (mode == 2'd0 || mode == 2'd3)
        check("R6 R7 captured", cap, {16'hFF20, VEC[v][15:0]});
      repeat (5) @(negedge clk);
    end

    // R3: exact timeout edge
    mode = 2'd1;
    begin
      int n;
      @(negedge clk) start = 1'b1;
      @(posedge clk);
      @(negedge clk) start = 1'b0;
      n = 1;
      while (!finished && n < 200) begin
        @(posedge clk);
        @(negedge clk);
        if (!finished) n++;
      end
      check("R3 timeout edges", n, TMO);
      check("R3 code", result, 1);
    end

    // R9: result held and pins idle while finished
    repeat (10) @(negedge clk);
    check("R9 finished held", finished, 1);
    check("R9 result held", result, 1);
    check("R9 cclk idle", cclk, 1);
    check("R9 prog idle", prog_pin, 1);
    check("R7 no ready after end", bit_ready, 0);

    // R8 restart after failure: success
    mode = 2'd0;
    pulse_start();
    check("R9 restart clears finished", finished, 0);
    send_word(16'h5A0F);
    wait_finish();
    check("R8 success", result, 0);
    check("R6 R7 restart stream", cap, {16'hFF20, 16'h5A0F});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule